// File: doc/BRIEF.md
# Cache SRAM Sleep-Enable Sequencer

This block drives the low-power enable pin of external cache SRAM devices from the processor's nap/sleep requests. It runs entirely in the cache clock domain. A one-cycle entry request raises the pin, provided the cache configuration enable bit is set. A one-cycle exit request drops it again. Every pin change is launched from a flop on the cache clock edge.

After the pin drops, the SRAMs need time to wake. The block therefore holds its "cache access permitted" output low for a guard window of `GUARD_CYCLES` cache clocks. Only after that window does it let the cache access logic issue traffic again. An entry request that arrives during the guard window puts the SRAMs straight back to sleep. Clearing the enable bit while the pin is high releases the pin and runs the same guard window.

The block has no data path. All pins are plain level or pulse controls, so no back-pressure rules apply.

Top module: `csram_sleep_seq`

## Requirements
- R1: The reset input is synchronous and active high. On the first cycle after reset is released, `sram_sleep_o` is 0 and `cache_access_ok_o` is 1.
- R2: When the block is idle with the pin low and access permitted, an entry pulse with `sleep_en`=1 and no exit pulse raises `sram_sleep_o` on the next clock edge. `cache_access_ok_o` falls at the same edge.
- R3: While the pin is high, it stays high until an exit pulse arrives or `sleep_en` is cleared. A further entry pulse in this state has no effect.
- R4: An exit pulse while the pin is high drops the pin at the next edge. `cache_access_ok_o` then stays 0 for exactly `GUARD_CYCLES` cycles, counted from the first cycle with the pin low, and returns to 1 on the cycle after that.
- R5: With `sleep_en`=0, an entry pulse is ignored. The pin stays 0, and `cache_access_ok_o` keeps the value it would have had without the pulse.
- R6: Clearing `sleep_en` while the pin is high drops the pin at the next edge and starts the full guard window of R4.
- R7: An entry pulse and an exit pulse in the same cycle are treated as an exit alone.
- R8: An entry pulse with `sleep_en`=1 during the guard window raises the pin at the next edge and discards the remaining count. The next exit then starts a fresh, full guard window.
- R9: `sram_sleep_o` and `cache_access_ok_o` are never 1 in the same cycle.
- R10: A `GUARD_CYCLES` value below 2 is raised to 2.
- R11: An exit pulse while the pin is low has no effect, whether or not a guard window is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cache clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_en | input | 1 | Configuration bit that permits the sleep pin to assert |
| nap_enter | input | 1 | One-cycle request to enter a low-power mode |
| nap_exit | input | 1 | One-cycle request to leave a low-power mode |
| sram_sleep_o | output | 1 | Registered low-power enable pin to the cache SRAMs |
| cache_access_ok_o | output | 1 | High when cache accesses may be issued |

## Verification
The assertions assume that `nap_enter` and `nap_exit` are already synchronous to `clk`. They also assume that the requests are single-cycle pulses whose meaning holds for the cycle they are seen in, and that `sleep_en` changes only between clock edges. The stimulus meets these assumptions by driving every input on the falling clock edge. It also puts simultaneous requests, requests while disabled and requests in the middle of a guard window deliberately at known guard counts. A second instance built with a guard length of 1 runs on the same inputs, so that the raised minimum can be observed at its ports.

// File: rtl/csram_sleep_pkg.sv
package csram_sleep_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE  = 2'b00,
    PH_ASLEEP = 2'b01,
    PH_GUARD  = 2'b10
  } sleep_phase_e;

  localparam int unsigned GUARD_FLOOR = 2;

  function automatic int unsigned guard_len(input int unsigned req);
    return (req < GUARD_FLOOR) ? GUARD_FLOOR : req;
  endfunction

endpackage

// File: rtl/csram_req_decode.sv
module csram_req_decode (
  input  logic sleep_en,
  input  logic nap_enter,
  input  logic nap_exit,
  output logic want_sleep,
  output logic want_wake
);
  // Exit outranks entry (R7); the enable bit gates entry (R5) and forces wake (R6).
  always_comb begin
    want_sleep = nap_enter & ~nap_exit & sleep_en;
    want_wake  = nap_exit | ~sleep_en;
  end
endmodule

// File: rtl/csram_guard_timer.sv
module csram_guard_timer #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (run && (cnt_q != LAST)) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);

  // R4: the count never passes the last guard cycle
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST) else $error("guard count out of range");

  // R4: a cleared timer starts from zero
  a_r4_clear_restarts: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0)) else $error("guard count not cleared");
endmodule

// File: rtl/csram_sleep_fsm.sv
module csram_sleep_fsm
  import csram_sleep_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic want_sleep,
  input  logic want_wake,
  input  logic guard_expire,
  output logic guard_clear,
  output logic guard_run,
  output logic sleep_pin,
  output logic access_ok
);
  sleep_phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_AWAKE:  if (want_sleep) ph_d = PH_ASLEEP;
      PH_ASLEEP: if (want_wake) ph_d = PH_GUARD;
      PH_GUARD: begin
        if (want_sleep)        ph_d = PH_ASLEEP;
        else if (guard_expire) ph_d = PH_AWAKE;
      end
      default:   ph_d = PH_AWAKE;
    endcase
  end

  assign guard_run   = (ph_q == PH_GUARD);
  assign guard_clear = (ph_q != PH_GUARD);

  // Pin and permit leave the block straight from flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= PH_AWAKE;
      sleep_pin <= 1'b0;
      access_ok <= 1'b1;
    end else begin
      ph_q      <= ph_d;
      sleep_pin <= (ph_d == PH_ASLEEP);
      access_ok <= (ph_d == PH_AWAKE);
    end
  end

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (!sleep_pin && access_ok)) else $error("bad state after reset");

  a_r2_entry: assert property (@(posedge clk) disable iff (rst)
    (access_ok && want_sleep) |=> (sleep_pin && !access_ok)) else $error("entry missed");

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (sleep_pin && !want_wake) |=> sleep_pin) else $error("pin dropped without cause");

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (sleep_pin && want_wake) |=> (!sleep_pin && !access_ok)) else $error("release wrong");

  a_r5_gate: assert property (@(posedge clk) disable iff (rst)
    !want_sleep |=> !$rose(sleep_pin)) else $error("pin rose without entry");

  a_r8_reentry: assert property (@(posedge clk) disable iff (rst)
    (!sleep_pin && !access_ok && want_sleep) |=> sleep_pin) else $error("guard re-entry missed");

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(sleep_pin && access_ok)) else $error("pin and permit both high");
endmodule

// File: rtl/csram_sleep_seq.sv
module csram_sleep_seq
  import csram_sleep_pkg::*;
#(
  parameter int unsigned GUARD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_en,
  input  logic nap_enter,
  input  logic nap_exit,
  output logic sram_sleep_o,
  output logic cache_access_ok_o
);
  // R10: requested length is raised to the floor
  localparam int unsigned GLEN = guard_len(GUARD_CYCLES);
  localparam int unsigned RW   = $clog2(GLEN + 1);

  logic want_sleep, want_wake;
  logic g_clear, g_run, g_expire;

  csram_req_decode u_dec (
    .sleep_en  (sleep_en),
    .nap_enter (nap_enter),
    .nap_exit  (nap_exit),
    .want_sleep(want_sleep),
    .want_wake (want_wake)
  );

  csram_guard_timer #(.LEN(GLEN)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (g_clear),
    .run   (g_run),
    .expire(g_expire)
  );

  csram_sleep_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .want_sleep  (want_sleep),
    .want_wake   (want_wake),
    .guard_expire(g_expire),
    .guard_clear (g_clear),
    .guard_run   (g_run),
    .sleep_pin   (sram_sleep_o),
    .access_ok   (cache_access_ok_o)
  );

  // Window checker: consecutive cycles with pin low and access blocked.
  logic [RW-1:0] low_run_q;
  logic          armed_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run_q <= '0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (sram_sleep_o || cache_access_ok_o) low_run_q <= '0;
      else if (low_run_q != RW'(GLEN)) low_run_q <= low_run_q + 1'b1;
    end
  end

  a_r4_min_guard: assert property (@(posedge clk) disable iff (rst)
    (armed_q && $rose(cache_access_ok_o)) |-> (low_run_q >= RW'(GLEN)))
    else $error("access resumed before guard elapsed");

  a_r6_disable_drops: assert property (@(posedge clk) disable iff (rst)
    !sleep_en |=> !sram_sleep_o) else $error("pin high while disabled");

  a_r7_exit_wins: assert property (@(posedge clk) disable iff (rst)
    (nap_enter && nap_exit) |=> !sram_sleep_o) else $error("entry beat exit");

  a_r11_exit_idle: assert property (@(posedge clk) disable iff (rst)
    (!sram_sleep_o && nap_exit) |=> !sram_sleep_o) else $error("exit raised pin");
endmodule

// File: tb/csram_sleep_seq_tb.sv
`timescale 1ns/1ps
module csram_sleep_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_en = 1'b0, nap_enter = 1'b0, nap_exit = 1'b0;
  logic pin_a, ok_a, pin_b, ok_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csram_sleep_seq #(.GUARD_CYCLES(4)) dut_i (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .nap_enter(nap_enter),
    .nap_exit(nap_exit), .sram_sleep_o(pin_a), .cache_access_ok_o(ok_a));

  // R10: requested length 1 must behave as 2
  csram_sleep_seq #(.GUARD_CYCLES(1)) dut_clamp_i (
    .clk(clk), .rst(rst), .sleep_en(sleep_en), .nap_enter(nap_enter),
    .nap_exit(nap_exit), .sram_sleep_o(pin_b), .cache_access_ok_o(ok_b));

  typedef struct {
    logic  p;
    logic  o;
    logic  p2;
    logic  o2;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: apply inputs on the falling edge, queue the result due after the next rise.
  task automatic step(input logic en, input logic ent, input logic ext,
                      input logic ep, input logic eo, input logic ep2, input logic eo2,
                      input string tag);
    exp_t e;
    @(negedge clk);
    sleep_en = en; nap_enter = ent; nap_exit = ext;
    e.p = ep; e.o = eo; e.p2 = ep2; e.o2 = eo2; e.tag = tag;
    q.push_back(e);
  endtask

  // Four cycles that follow the first pin-low cycle (main guard 4, clamped guard 2).
  task automatic guard_tail(input logic en, input logic ent1, input logic ext1, input string tag);
    step(en, ent1, ext1, 0, 0, 0, 0, {tag, " R4 guard cycle 2"});
    step(en, 0, 0, 0, 0, 0, 1, {tag, " R4 guard cycle 3 / R10 clamp released"});
    step(en, 0, 0, 0, 0, 0, 1, {tag, " R4 guard cycle 4 / R10"});
    step(en, 0, 0, 0, 1, 0, 1, {tag, " R4 access resumes"});
  endtask

  // Monitor: pop and compare just after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "pin", pin_a, e.p);
        chk(e.tag, "access_ok", ok_a, e.o);
        chk(e.tag, "clamp pin", pin_b, e.p2);
        chk(e.tag, "clamp access_ok", ok_b, e.o2);
        chk("R9", "pin&ok", pin_a & ok_a, 1'b0);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step(1, 0, 0, 0, 1, 0, 1, "R1 reset state");
    // R2 entry, R3 hold and repeated entry, R4 exit and guard
    step(1, 1, 0, 1, 0, 1, 0, "R2 entry");
    step(1, 0, 0, 1, 0, 1, 0, "R3 hold");
    step(1, 1, 0, 1, 0, 1, 0, "R3 entry while asleep");
    step(1, 0, 1, 0, 0, 0, 0, "R4 exit drops pin");
    guard_tail(1, 0, 0, "S1");
    // R11 exit while awake
    step(1, 0, 1, 0, 1, 0, 1, "R11 exit while awake");
    // R5 disabled entry
    step(0, 1, 0, 0, 1, 0, 1, "R5 entry ignored when disabled");
    step(0, 0, 0, 0, 1, 0, 1, "R5 still awake");
    // R7 simultaneous in awake, then in asleep
    step(1, 1, 1, 0, 1, 0, 1, "R7 both while awake");
    step(1, 1, 0, 1, 0, 1, 0, "R2 entry again");
    step(1, 1, 1, 0, 0, 0, 0, "R7 both while asleep, exit wins");
    guard_tail(1, 0, 1, "S2 R11 exit in guard");
    // R8 re-entry in guard, then fresh full guard
    step(1, 1, 0, 1, 0, 1, 0, "R8 setup entry");
    step(1, 0, 1, 0, 0, 0, 0, "R8 exit");
    step(1, 1, 0, 1, 0, 1, 0, "R8 entry during guard");
    step(1, 0, 0, 1, 0, 1, 0, "R8 asleep again");
    step(1, 0, 1, 0, 0, 0, 0, "R8 exit restarts guard");
    guard_tail(1, 0, 0, "S3 R8 full guard");
    // R6 enable cleared while asleep
    step(1, 1, 0, 1, 0, 1, 0, "R6 setup entry");
    step(0, 0, 0, 0, 0, 0, 0, "R6 enable cleared drops pin");
    guard_tail(0, 1, 0, "S4 R6/R5 entry disabled in guard");
    step(0, 0, 0, 0, 1, 0, 1, "R6 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule